// File: doc/BRIEF.md
# Ethernet Transmit Status Word

This block keeps the transmit status of a 10/100 Ethernet MAC and presents it as one read-only status word. The transmitter reports what happens on the wire through single-cycle strobes: a frame starts, a frame ends, the preamble is over, a collision occurs, the destination is broadcast, an event counter has rolled over. The block also receives level inputs: the carrier-sense sample, a "waiting to defer" level, the active-low link pin, the transmit-enable control bit and the carrier-monitor option. Each flag in the word has its own set and clear rule. Some flags clear when a frame ends. Some clear when transmit is enabled again. One clears when software reads the event counters.

All time limits count a byte-time tick input, which pulses once every eight bit times. The same thresholds therefore hold at both line rates. A lost carrier or a late collision is a fatal error. For a fatal error the block requests that transmit enable be cleared, and it issues that request only after the current frame has ended. A late collision also produces a jam request. When a frame completes, the block presents a frozen copy of the word for one cycle, so that it can be written as the first word of the packet buffer. The live word keeps the last completion result while the transmitter is stopped.

Top module: `tx_status_reg`

## Requirements
- R1: Bit 1 of `status` (link up) equals the inverse of `link_n` as sampled at the previous clock edge. `link_irq` is high for exactly the one cycle in which bit 1 has just changed value.
- R2: Bit 7 (counter rollover) sets one cycle after `cnt_rollover` and clears one cycle after `cnt_read`. If both occur in the same cycle, the bit is set.
- R3: Bit 4 (excessive deferral) sets on the byte tick that makes `defer_wait` held for more than DEFER_LIMIT (default 3036) consecutive byte ticks. It clears one cycle after `frame_end`, unless it sets again in that same cycle.
- R4: Bit 3 (deferred) sets when `carrier_sense` is high while the gap window is open. The window opens in the cycle after `frame_end` and closes after IFG_WIN_BYTES (default 8) byte ticks, or when a frame starts. Bit 3 clears one cycle after `frame_end`.
- R5: Bit 5 (lost carrier) sets when `preamble_end` occurs inside a frame while `mon_carrier` is 1 and `carrier_sense` is 0. When `mon_carrier` is 0, `preamble_end` has no effect on the bit. A rising edge of `tx_enable` clears the bit.
- R6: Bit 6 (late collision) sets, and `jam_req` pulses for one cycle, when `collision` occurs inside a frame after at least LATE_COL_BYTES (default 64) byte ticks since the frame started. A collision after fewer ticks has no effect. A rising edge of `tx_enable` clears the bit.
- R7: Bit 2 (broadcast) takes the value of `frame_bcast` at each accepted `frame_start`. A `frame_start` arriving while `tx_enable` is 0 is ignored.
- R8: If a fatal error (bit 5 or bit 6 setting) occurs during a frame, `tx_en_clr` pulses for one cycle, in the cycle after that frame's `frame_end`, and never earlier.
- R9: One cycle after `frame_end`, `snap_valid` is high for one cycle. `snap_word` then holds the status word as it stood in the `frame_end` cycle, with bit 0 set to 1 when the frame had no fatal error. Bit 0 of `status` takes the same value and clears on the next accepted frame start.
- R10: After reset, `status` is zero. Bit 8 repeats `tx_enable` one cycle late. Bits 15:9 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_tick | input | 1 | One pulse per byte time |
| frame_start | input | 1 | Strobe: a transmit frame begins |
| frame_bcast | input | 1 | Destination is broadcast, valid with frame_start |
| preamble_end | input | 1 | Strobe: preamble finished |
| frame_end | input | 1 | Strobe: frame completed |
| carrier_sense | input | 1 | Carrier-sense sample |
| collision | input | 1 | Collision detected |
| defer_wait | input | 1 | Pending frame is waiting on the medium |
| cnt_rollover | input | 1 | An event counter reached 15 |
| cnt_read | input | 1 | Event counter register was read |
| link_n | input | 1 | Link pin, active low |
| tx_enable | input | 1 | Transmit enable control bit |
| mon_carrier | input | 1 | Carrier monitoring option |
| status | output | 16 | Live status word |
| tx_en_clr | output | 1 | Request to clear transmit enable |
| jam_req | output | 1 | Request to send jam |
| link_irq | output | 1 | Link-change interrupt strobe |
| snap_valid | output | 1 | Snapshot word valid |
| snap_word | output | 16 | Status word frozen at frame completion |

## Verification
Every result appears one clock edge after the input that causes it. This holds for status flags, the link interrupt, the jam request, the enable-clear request and the snapshot strobe. The bench drives inputs 1 ns after a rising edge and compares all outputs 1 ns after the next rising edge against its own per-cycle expectation. This applies to randomly generated frames and to directed cases. The directed cases cover the 3036/3037 deferral boundary, the 63/64 collision boundary, set-and-clear in the same cycle, and the clear being held back until the frame ends.

// File: rtl/tx_status_reg.sv
module tx_status_reg #(
  parameter int STAT_W         = 16,
  parameter int LATE_COL_BYTES = 64,
  parameter int DEFER_LIMIT    = 3036,
  parameter int IFG_WIN_BYTES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_tick,
  input  logic              frame_start,
  input  logic              frame_bcast,
  input  logic              preamble_end,
  input  logic              frame_end,
  input  logic              carrier_sense,
  input  logic              collision,
  input  logic              defer_wait,
  input  logic              cnt_rollover,
  input  logic              cnt_read,
  input  logic              link_n,
  input  logic              tx_enable,
  input  logic              mon_carrier,
  output logic [STAT_W-1:0] status,
  output logic              tx_en_clr,
  output logic              jam_req,
  output logic              link_irq,
  output logic              snap_valid,
  output logic [STAT_W-1:0] snap_word
);
  localparam int BC_W = $clog2(LATE_COL_BYTES + 1);
  localparam int DC_W = $clog2(DEFER_LIMIT + 1);
  localparam int IC_W = $clog2(IFG_WIN_BYTES + 1);
  localparam logic [BC_W-1:0] BC_MAX = BC_W'(LATE_COL_BYTES);
  localparam logic [DC_W-1:0] DC_MAX = DC_W'(DEFER_LIMIT);
  localparam logic [IC_W-1:0] IC_LAST = IC_W'(IFG_WIN_BYTES - 1);

  logic in_frame, ten_q, pend, ifg_open;
  logic [BC_W-1:0] bcnt;
  logic [DC_W-1:0] dcnt;
  logic [IC_W-1:0] icnt;
  logic f_ok, f_link, f_bc, f_defr, f_exc, f_lost, f_late, f_roll;

  wire start_ok   = frame_start & tx_enable;
  wire ten_rise   = tx_enable & ~ten_q;
  wire late_hit   = collision & in_frame & (bcnt >= BC_MAX);
  wire lost_hit   = preamble_end & in_frame & mon_carrier & ~carrier_sense;
  wire exc_hit    = defer_wait & byte_tick & (dcnt == DC_MAX);
  wire defr_hit   = ifg_open & carrier_sense;
  wire fatal_now  = late_hit | lost_hit;
  wire frame_good = ~(f_lost | f_late | fatal_now);

  wire [8:0] live = {ten_q, f_roll, f_late, f_lost, f_exc, f_defr, f_bc, f_link, f_ok};
  assign status = {{(STAT_W-9){1'b0}}, live};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      bcnt     <= '0;
    end else begin
      if (start_ok) begin
        in_frame <= 1'b1;
        bcnt     <= '0;
      end else begin
        if (frame_end) in_frame <= 1'b0;
        if (in_frame && byte_tick && bcnt != BC_MAX) bcnt <= bcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          dcnt <= '0;
    else if (!defer_wait)                dcnt <= '0;
    else if (byte_tick && dcnt != DC_MAX) dcnt <= dcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifg_open <= 1'b0;
      icnt     <= '0;
    end else if (frame_end) begin
      ifg_open <= 1'b1;
      icnt     <= '0;
    end else if (start_ok) begin
      ifg_open <= 1'b0;
    end else if (ifg_open && byte_tick) begin
      icnt <= icnt + 1'b1;
      if (icnt == IC_LAST) ifg_open <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_ok <= 1'b0; f_link <= 1'b0; f_bc <= 1'b0; f_defr <= 1'b0;
      f_exc <= 1'b0; f_lost <= 1'b0; f_late <= 1'b0; f_roll <= 1'b0;
      ten_q <= 1'b0; pend <= 1'b0;
      tx_en_clr <= 1'b0; jam_req <= 1'b0; link_irq <= 1'b0;
      snap_valid <= 1'b0; snap_word <= '0;
    end else begin
      ten_q    <= tx_enable;
      f_link   <= ~link_n;
      link_irq <= ~link_n ^ f_link;
      if (start_ok) f_bc <= frame_bcast;
      f_defr <= defr_hit | (f_defr & ~frame_end);
      f_exc  <= exc_hit  | (f_exc  & ~frame_end);
      f_lost <= lost_hit | (f_lost & ~ten_rise);
      f_late <= late_hit | (f_late & ~ten_rise);
      f_roll <= cnt_rollover | (f_roll & ~cnt_read);
      if (frame_end)     f_ok <= frame_good;
      else if (start_ok) f_ok <= 1'b0;
      tx_en_clr  <= (pend | fatal_now) & frame_end;
      pend       <= (pend | fatal_now) & ~frame_end;
      jam_req    <= late_hit;
      snap_valid <= frame_end;
      if (frame_end) snap_word <= {{(STAT_W-9){1'b0}}, live[8:1], frame_good};
    end
  end
endmodule

module tx_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       frame_bcast,
  input logic       frame_end,
  input logic       tx_enable,
  input logic       link_n,
  input logic       cnt_rollover,
  input logic       cnt_read,
  input logic       collision,
  input logic       preamble_end,
  input logic       defer_wait,
  input logic       byte_tick,
  input logic [8:0] st,
  input logic       link_irq,
  input logic       tx_en_clr,
  input logic       jam_req,
  input logic       snap_valid
);
  a_r1_link_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> st[1] == !$past(link_n));
  a_r1_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    link_irq |-> st[1] != $past(st[1]));
  a_r2_roll_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rollover |=> st[7]);
  a_r2_roll_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_read && !cnt_rollover |=> !st[7]);
  a_r3_exc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !(defer_wait && byte_tick) |=> !st[4]);
  a_r6_jam_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    jam_req |-> st[6]);
  a_r5_r6_reenable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[8]) && !$past(collision) && !$past(preamble_end) |-> !st[5] && !st[6]);
  a_r7_bcast_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && tx_enable |=> st[2] == $past(frame_bcast));
  a_r8_clr_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_clr |-> $past(frame_end));
  a_r9_snap_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid |-> $past(frame_end));
endmodule

bind tx_status_reg tx_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_bcast(frame_bcast),
  .frame_end(frame_end), .tx_enable(tx_enable), .link_n(link_n),
  .cnt_rollover(cnt_rollover), .cnt_read(cnt_read), .collision(collision),
  .preamble_end(preamble_end), .defer_wait(defer_wait), .byte_tick(byte_tick),
  .st(status[8:0]), .link_irq(link_irq), .tx_en_clr(tx_en_clr),
  .jam_req(jam_req), .snap_valid(snap_valid)
);

// File: tb/tx_status_reg_bench.sv
module tx_status_reg_bench;
  localparam int LATE = 64;
  localparam int DEFL = 3036;
  localparam int WIN  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_tick = 0, frame_start = 0, frame_bcast = 0, preamble_end = 0, frame_end = 0;
  logic carrier_sense = 0, collision = 0, defer_wait = 0, cnt_rollover = 0, cnt_read = 0;
  logic link_n = 1, tx_enable = 0, mon_carrier = 0;
  logic [15:0] status, snap_word;
  logic tx_en_clr, jam_req, link_irq, snap_valid;

  int checks = 0, errors = 0;
  bit done = 0;

  tx_status_reg u_tx_status_reg (
    .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick), .frame_start(frame_start),
    .frame_bcast(frame_bcast), .preamble_end(preamble_end), .frame_end(frame_end),
    .carrier_sense(carrier_sense), .collision(collision), .defer_wait(defer_wait),
    .cnt_rollover(cnt_rollover), .cnt_read(cnt_read), .link_n(link_n),
    .tx_enable(tx_enable), .mon_carrier(mon_carrier), .status(status),
    .tx_en_clr(tx_en_clr), .jam_req(jam_req), .link_irq(link_irq),
    .snap_valid(snap_valid), .snap_word(snap_word));

  always #5 clk = ~clk;

  // expected-state model built from the requirements
  logic m_in = 0, m_open = 0, m_ten = 0, m_pend = 0;
  int   m_bcnt = 0, m_dcnt = 0, m_icnt = 0;
  logic m_ok = 0, m_link = 0, m_bc = 0, m_defr = 0, m_exc = 0, m_lost = 0, m_late = 0, m_roll = 0;
  logic m_clr = 0, m_jam = 0, m_irq = 0, m_sv = 0;
  logic [15:0] m_sw = 0;

  function automatic logic [15:0] m_word();
    return {7'd0, m_ten, m_roll, m_late, m_lost, m_exc, m_defr, m_bc, m_link, m_ok};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic start_ok, rise, late_hit, lost_hit, exc_hit, defr_hit, fatal, good;
    logic [15:0] cur;
    start_ok = frame_start && tx_enable;
    rise     = tx_enable && !m_ten;
    late_hit = collision && m_in && (m_bcnt >= LATE);
    lost_hit = preamble_end && m_in && mon_carrier && !carrier_sense;
    exc_hit  = defer_wait && byte_tick && (m_dcnt == DEFL);
    defr_hit = m_open && carrier_sense;
    fatal    = late_hit || lost_hit;
    good     = !(m_lost || m_late || fatal);
    cur = m_word(); cur[0] = good;
    if (start_ok) m_bcnt = 0; else if (m_in && byte_tick && m_bcnt < LATE) m_bcnt++;
    m_in = start_ok ? 1'b1 : (frame_end ? 1'b0 : m_in);
    if (!defer_wait) m_dcnt = 0; else if (byte_tick && m_dcnt < DEFL) m_dcnt++;
    if (frame_end) begin m_open = 1; m_icnt = 0; end
    else if (start_ok) m_open = 0;
    else if (m_open && byte_tick) begin
      if (m_icnt == WIN - 1) m_open = 0;
      m_icnt++;
    end
    m_sv = frame_end;
    if (frame_end) m_sw = cur;
    m_clr  = (m_pend || fatal) && frame_end;
    m_pend = (m_pend || fatal) && !frame_end;
    m_jam  = late_hit;
    m_irq  = (!link_n) != m_link;
    m_link = !link_n;
    if (start_ok) m_bc = frame_bcast;
    m_defr = defr_hit || (m_defr && !frame_end);
    m_exc  = exc_hit  || (m_exc  && !frame_end);
    m_lost = lost_hit || (m_lost && !rise);
    m_late = late_hit || (m_late && !rise);
    m_roll = cnt_rollover || (m_roll && !cnt_read);
    if (frame_end) m_ok = good; else if (start_ok) m_ok = 0;
    m_ten = tx_enable;
  endtask

  task automatic compare_all();
    logic [15:0] e;
    e = m_word();
    chk("R9 tx_ok bit",    16'(status[0]), 16'(e[0]));
    chk("R1 link bit",     16'(status[1]), 16'(e[1]));
    chk("R7 bcast bit",    16'(status[2]), 16'(e[2]));
    chk("R4 deferred bit", 16'(status[3]), 16'(e[3]));
    chk("R3 exc_def bit",  16'(status[4]), 16'(e[4]));
    chk("R5 lost bit",     16'(status[5]), 16'(e[5]));
    chk("R6 late bit",     16'(status[6]), 16'(e[6]));
    chk("R2 roll bit",     16'(status[7]), 16'(e[7]));
    chk("R10 upper bits",  16'(status[15:8]), 16'(e[15:8]));
    chk("R1 link_irq",     16'(link_irq), 16'(m_irq));
    chk("R8 tx_en_clr",    16'(tx_en_clr), 16'(m_clr));
    chk("R6 jam_req",      16'(jam_req), 16'(m_jam));
    chk("R9 snap_valid",   16'(snap_valid), 16'(m_sv));
    if (m_sv) chk("R9 snap_word", snap_word, m_sw);
  endtask

  task automatic step();
    model_step();
    @(posedge clk); #1;
    compare_all();
    byte_tick = 0; frame_start = 0; frame_bcast = 0; preamble_end = 0; frame_end = 0;
    collision = 0; cnt_rollover = 0; cnt_read = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset status", status, 16'h0000);
    rst_n = 1;
    tx_enable = 1;
    step();
    chk("R10 enable mirrored", 16'(status[8]), 16'd1);

    // R2 set wins over read in one cycle
    cnt_rollover = 1; cnt_read = 1; step();
    chk("R2 set wins", 16'(status[7]), 16'd1);
    cnt_read = 1; step();
    chk("R2 read clears", 16'(status[7]), 16'd0);

    // R3 deferral boundary: 3036 ticks no flag, 3037th sets
    defer_wait = 1;
    for (int i = 0; i < DEFL; i++) begin byte_tick = 1; step(); end
    chk("R3 at limit", 16'(status[4]), 16'd0);
    byte_tick = 1; step();
    chk("R3 over limit", 16'(status[4]), 16'd1);
    byte_tick = 1; frame_start = 1; step();
    byte_tick = 1; frame_end = 1; step();
    chk("R3 set wins at end", 16'(status[4]), 16'd1);
    defer_wait = 0; step();

    // R7 start ignored while disabled
    tx_enable = 0; step();
    frame_start = 1; frame_bcast = 1; step();
    chk("R7 start ignored", 16'(status[2]), 16'd0);
    tx_enable = 1; step();

    // R6 collision boundary and R8 deferred clear
    frame_start = 1; step();
    for (int i = 0; i < LATE - 1; i++) begin byte_tick = 1; step(); end
    collision = 1; step();
    chk("R6 early collision", 16'(status[6]), 16'd0);
    byte_tick = 1; step();
    collision = 1; step();
    chk("R6 late collision", 16'(status[6]), 16'd1);
    chk("R6 jam", 16'(jam_req), 16'd1);
    step();
    chk("R8 no clear mid-frame", 16'(tx_en_clr), 16'd0);
    frame_end = 1; step();
    chk("R8 clear after end", 16'(tx_en_clr), 16'd1);
    chk("R9 snapshot bad frame", 16'(snap_word[0]), 16'd0);
    tx_enable = 0; step();
    tx_enable = 1; step();
    chk("R6 reenable clears", 16'(status[6]), 16'd0);

    // R5 with monitoring off then on
    frame_start = 1; step();
    mon_carrier = 0; preamble_end = 1; step();
    chk("R5 monitor off", 16'(status[5]), 16'd0);
    mon_carrier = 1; preamble_end = 1; step();
    chk("R5 lost carrier", 16'(status[5]), 16'd1);
    frame_end = 1; step();
    tx_enable = 0; step();
    tx_enable = 1; step();

    // R4 carrier inside and after the gap window
    frame_start = 1; step();
    frame_end = 1; step();
    for (int i = 0; i < WIN; i++) begin byte_tick = 1; step(); end
    carrier_sense = 1; step();
    chk("R4 after window", 16'(status[3]), 16'd0);
    carrier_sense = 0;
    frame_start = 1; step();
    frame_end = 1; step();
    carrier_sense = 1; step();
    chk("R4 inside window", 16'(status[3]), 16'd1);
    carrier_sense = 0;

    // random mix
    for (int n = 0; n < 6000; n++) begin
      byte_tick     = ($urandom % 2) == 0;
      carrier_sense = ($urandom % 3) == 0;
      if (($urandom % 40) == 0) defer_wait = ~defer_wait;
      if (($urandom % 60) == 0) link_n = ~link_n;
      if (($urandom % 30) == 0) mon_carrier = ~mon_carrier;
      cnt_rollover = ($urandom % 25) == 0;
      cnt_read     = ($urandom % 25) == 0;
      if (m_in) begin
        frame_end    = ($urandom % 90) == 0;
        preamble_end = ($urandom % 30) == 0;
        collision    = ($urandom % 40) == 0;
      end else begin
        frame_start = ($urandom % 8) == 0;
        frame_bcast = ($urandom % 2) == 0;
      end
      if (tx_en_clr) tx_enable = 0;
      else if (!tx_enable && ($urandom % 10) == 0) tx_enable = 1;
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule